// File: doc/BRIEF.md
# Two-Wire Slave Front End for a 16-bit Register Map

This block sits between a two-wire serial bus and a bank of 16-bit registers held outside it. It watches already synchronised clock and data inputs, recognises bus framing, answers to one fixed 7-bit device address, and moves bytes between the bus and a byte-addressed register space. The register space is addressed through an internal byte pointer. The pointer is loaded by the first byte a master writes and advances by itself as bytes go by.

Reads are served one byte at a time from an external read port that the pointer indexes. Writes are collected in pairs. The byte at an even address is held back, and the 16-bit value is handed to the register side in a single commit pulse only when the byte at the next odd address arrives. One command value written to the command word resets the block instead of being committed. The block answers with an acknowledge bit by pulling the data line low through an open-drain enable.

Top module: `i2c_reg16_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0x36 (0x6C to write, 0x6D to read). Any other address gets no acknowledge, and the rest of that frame has no effect.
- R2: In a write frame, the first byte after the address loads the byte pointer. It is acknowledged and produces no commit.
- R3: Bits travel most significant first. The byte at the even address is the upper half of the 16-bit word, and the byte at the following odd address is the lower half.
- R4: The pointer advances by one after every data byte written or read. A 16-bit write starting at an even address commits one word per pair of bytes.
- R5: A commit (`wr_en` high for one cycle, with an even `wr_addr` and `wr_data` = {even byte, odd byte}) happens only once both bytes of a pair have arrived in the same frame. A lone even byte, a frame that starts on an odd address, or a byte cut off partway produces no commit.
- R6: Pairs at 0x02, 0x04 and 0x08 are read-only, and every address from 0x50 to 0xFD is outside the writable map. Bytes written there are acknowledged but never committed.
- R7: Once the pointer has gone past 0xFF, read bytes return 0xFF, and further bytes never commit.
- R8: A read is a pointer write, a repeated START, address 0x6D, and then data bytes. After the master answers a byte with no acknowledge, the block stops driving the data line.
- R9: Writing 0x5400 to the word at 0xFE pulses `soft_rst`, leaves the final byte unacknowledged, clears the pointer to 0 and commits nothing. Any other value written there commits normally.
- R10: A START or STOP in the middle of a frame returns the block to waiting for an address and drops a held even byte.
- R11: After reset the data line is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (wired level) |
| sda_oe | output | 1 | When high, pull the data line low |
| rd_addr | output | 8 | Byte address of the next read byte |
| rd_data | input | 8 | Register byte at `rd_addr`, combinational |
| wr_en | output | 1 | One-cycle 16-bit commit strobe |
| wr_addr | output | 8 | Even byte address of the committed word |
| wr_data | output | 16 | Committed word, upper byte from the even address |
| soft_rst | output | 1 | One-cycle pulse on the reset command |

## Verification
The assertions assume that the inputs are already clean and synchronous to `clk`. Each bus-clock level is taken to last several system clocks, so rising and falling edges never fall in adjacent cycles. Data is assumed to change only while the bus clock is low, except at deliberate START and STOP conditions. The bench's bit tasks hold every bus phase for a fixed number of system clocks and move the data line only in the low phase, apart from the framing tasks. Random frames vary the pointer, the byte count and the truncation point within those rules.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int PTR_W  = BYTE_W + 1;

  typedef enum logic [3:0] {
    LK_IDLE, LK_ADDR, LK_AACK, LK_WDAT, LK_WACK,
    LK_RDAT, LK_RACK, LK_RNXT, LK_SKIP
  } link_st_t;

  // Is the word at even byte address a writable?
  function automatic logic pair_writable(input logic [BYTE_W-1:0] a,
                                         input logic [127:0] ro,
                                         input logic [BYTE_W-1:0] lim,
                                         input logic [BYTE_W-1:0] cmd);
    if (a == cmd) return 1'b1;
    if (a > lim)  return 1'b0;
    return ~ro[a[BYTE_W-1:1]];
  endfunction

  // Byte served for a pointer; beyond the map end all ones.
  function automatic logic [BYTE_W-1:0] fetch_byte(input logic [PTR_W-1:0] p,
                                                   input logic [BYTE_W-1:0] d);
    return p[PTR_W-1] ? {BYTE_W{1'b1}} : d;
  endfunction

  // Pointer advance, saturating one past the last address.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p[PTR_W-1] ? p : p + 1'b1;
  endfunction
endpackage

// File: rtl/i2cr_bus_events.sv
module i2cr_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cr_link.sv
module i2cr_link
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              abort,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wbyte_ev,
  output logic              wfirst,
  output logic [BYTE_W-1:0] wbyte,
  output logic              rbyte_ev
);
  link_st_t          st;
  logic [2:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw, ph, first;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {sh[BYTE_W-2:0], sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LK_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; ph <= 1'b0;
      first <= 1'b0; sda_oe <= 1'b0;
      wbyte_ev <= 1'b0; wfirst <= 1'b0; wbyte <= '0; rbyte_ev <= 1'b0;
    end else begin
      wbyte_ev <= 1'b0;
      rbyte_ev <= 1'b0;
      if (abort) begin
        st <= LK_IDLE; sda_oe <= 1'b0; ph <= 1'b0;
      end else if (start_ev) begin
        st <= LK_ADDR; cnt <= '0; sda_oe <= 1'b0; ph <= 1'b0;
      end else if (stop_ev) begin
        st <= LK_IDLE; sda_oe <= 1'b0; ph <= 1'b0;
      end else begin
        unique case (st)
          LK_ADDR: if (scl_rise) begin
            sh  <= byte_in;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              rw <= byte_in[0];
              st <= (byte_in[BYTE_W-1:1] == DEV_ADDR) ? LK_AACK : LK_SKIP;
            end
          end
          LK_AACK: if (scl_fall) begin
            if (!ph) begin
              sda_oe <= 1'b1; ph <= 1'b1;
            end else begin
              ph <= 1'b0; cnt <= '0;
              if (rw) begin
                sh <= rd_byte; sda_oe <= ~rd_byte[BYTE_W-1]; st <= LK_RDAT;
              end else begin
                sda_oe <= 1'b0; first <= 1'b1; st <= LK_WDAT;
              end
            end
          end
          LK_WDAT: if (scl_rise) begin
            sh  <= byte_in;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              wbyte_ev <= 1'b1; wbyte <= byte_in; wfirst <= first;
              first <= 1'b0; st <= LK_WACK;
            end
          end
          LK_WACK: if (scl_fall) begin
            if (!ph) begin
              sda_oe <= 1'b1; ph <= 1'b1;
            end else begin
              sda_oe <= 1'b0; ph <= 1'b0; cnt <= '0; st <= LK_WDAT;
            end
          end
          LK_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                rbyte_ev <= 1'b1; st <= LK_RACK; ph <= 1'b0;
              end
            end else if (scl_fall) begin
              sda_oe <= ~sh[BYTE_W-2];
              sh     <= {sh[BYTE_W-2:0], 1'b0};
            end
          end
          LK_RACK: begin
            if (scl_fall && !ph) begin
              sda_oe <= 1'b0; ph <= 1'b1;
            end else if (scl_rise && ph) begin
              ph <= 1'b0;
              st <= sda_i ? LK_SKIP : LK_RNXT;
            end
          end
          LK_RNXT: if (scl_fall) begin
            sh <= rd_byte; sda_oe <= ~rd_byte[BYTE_W-1]; cnt <= '0; st <= LK_RDAT;
          end
          default: ;
        endcase
      end
    end
  end

  // R8: the line only moves while the bus clock is low, apart from framing and reset
  a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(start_ev || stop_ev || abort)) |-> $stable(sda_oe));
  // R10: a STOP always frees the data line
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
  // R9: the reset command leaves the final byte unacknowledged
  a_r9_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !sda_oe);
  // R1: a foreign address never sees the line pulled
  a_r1_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_SKIP && $past(st) == LK_SKIP) |-> !sda_oe);
endmodule

// File: rtl/i2cr_regport.sv
module i2cr_regport
  import i2cr_pkg::*;
#(
  parameter logic [127:0]      RO_PAIRS = 128'h16,
  parameter logic [BYTE_W-1:0] WR_LIMIT = 8'h4F,
  parameter logic [BYTE_W-1:0] CMD_ADDR = 8'hFE,
  parameter logic [REG_W-1:0]  RST_CODE = 16'h5400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wbyte_ev,
  input  logic              wfirst,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              rbyte_ev,
  input  logic              frame_end,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic              soft_rst
);
  logic              pend;
  logic [BYTE_W-1:0] msb;
  logic [BYTE_W-1:0] pair_a;
  logic              pair_ok, is_cmd;

  assign pair_a  = {ptr[BYTE_W-1:1], 1'b0};
  assign pair_ok = pend && pair_writable(pair_a, RO_PAIRS, WR_LIMIT, CMD_ADDR);
  assign is_cmd  = (pair_a == CMD_ADDR) && ({msb, wbyte} == RST_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; pend <= 1'b0; msb <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; soft_rst <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      soft_rst <= 1'b0;
      if (frame_end) pend <= 1'b0;
      if (wbyte_ev) begin
        if (wfirst) begin
          ptr  <= {1'b0, wbyte};
          pend <= 1'b0;
        end else if (!ptr[PTR_W-1]) begin
          ptr <= ptr_step(ptr);
          if (!ptr[0]) begin
            pend <= 1'b1;
            msb  <= wbyte;
          end else begin
            pend <= 1'b0;
            if (pair_ok && is_cmd) begin
              soft_rst <= 1'b1;
              ptr      <= '0;
            end else if (pair_ok) begin
              wr_en   <= 1'b1;
              wr_addr <= pair_a;
              wr_data <= {msb, wbyte};
            end
          end
        end
      end
      if (rbyte_ev) ptr <= ptr_step(ptr);
    end
  end

  // R5: commits land on word boundaries
  a_r5_commit_even: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_addr[0]);
  // R6: nothing commits outside the writable window
  a_r6_commit_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= WR_LIMIT || wr_addr == CMD_ADDR));
  // R9: reset command never doubles as a commit
  a_r9_no_commit_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !wr_en);
  // R4 / R7: a read byte moves the pointer by one or holds it past the end
  a_r4_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    rbyte_ev |=> (ptr == $past(ptr) + 1'b1 || ($past(ptr[PTR_W-1]) && ptr[PTR_W-1])));
endmodule

// File: rtl/i2c_reg16_slave.sv
module i2c_reg16_slave
  import i2cr_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR = 7'h36,
  parameter logic [127:0]      RO_PAIRS = 128'h16,
  parameter logic [BYTE_W-1:0] WR_LIMIT = 8'h4F,
  parameter logic [BYTE_W-1:0] CMD_ADDR = 8'hFE,
  parameter logic [REG_W-1:0]  RST_CODE = 16'h5400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic              soft_rst
);
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic wbyte_ev, wfirst, rbyte_ev;
  logic [BYTE_W-1:0] wbyte, rd_byte;
  logic [PTR_W-1:0]  ptr;

  i2cr_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign rd_byte = fetch_byte(ptr, rd_data);
  assign rd_addr = ptr[BYTE_W-1:0];

  i2cr_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .abort(soft_rst),
    .rd_byte(rd_byte), .sda_oe(sda_oe),
    .wbyte_ev(wbyte_ev), .wfirst(wfirst), .wbyte(wbyte), .rbyte_ev(rbyte_ev)
  );

  i2cr_regport #(
    .RO_PAIRS(RO_PAIRS), .WR_LIMIT(WR_LIMIT),
    .CMD_ADDR(CMD_ADDR), .RST_CODE(RST_CODE)
  ) u_port (
    .clk(clk), .rst_n(rst_n),
    .wbyte_ev(wbyte_ev), .wfirst(wfirst), .wbyte(wbyte),
    .rbyte_ev(rbyte_ev), .frame_end(start_ev | stop_ev),
    .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .soft_rst(soft_rst)
  );
endmodule

// File: tb/i2c_reg16_slave_tb_top.sv
module i2c_reg16_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_en, soft_rst;
  logic [7:0] rd_addr, rd_data, wr_addr;
  logic [15:0] wr_data;
  wire sda_bus;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  assign rd_data = mem[rd_addr];

  i2c_reg16_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .soft_rst(soft_rst)
  );

  logic [23:0] got_q[$];
  logic [23:0] exp_q[$];
  int soft_cnt = 0;
  int got_base = 0;
  int total = 0;
  int bad = 0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  logic ackv [10];

  always @(posedge clk) begin
    if (wr_en) got_q.push_back({wr_addr, wr_data});
    if (soft_rst) soft_cnt++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q); tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input logic nak, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      b[i] = x;
    end
    put_bit(nak);
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] p, input int n, input int cut);
    bus_start();
    send_byte(8'h6C, ackv[0]);
    send_byte(p, ackv[1]);
    for (int i = 0; i < n; i++) send_byte(txb[i], ackv[i+2]);
    for (int i = 0; i < cut; i++) put_bit(1'($urandom_range(0, 1)));
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] p, input int n, input bit set_ptr);
    bus_start();
    if (set_ptr) begin
      send_byte(8'h6C, ackv[0]);
      send_byte(p, ackv[1]);
      bus_start();
    end
    send_byte(8'h6D, ackv[2]);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rxb[i]);
    check("R8 line released after master NAK", 32'(sda_oe), 32'd0);
    bus_stop();
  endtask

  function automatic bit bwritable(input int a);
    return (a == 254) || (a <= 79 && a != 2 && a != 4 && a != 8);
  endfunction

  function automatic logic [7:0] exp_rd(input int p);
    return (p < 256) ? mem[p] : 8'hFF;
  endfunction

  task automatic model_write(input int p0, input int n);
    int p;
    bit pend;
    logic [7:0] msb;
    p = p0; pend = 1'b0; msb = '0;
    for (int i = 0; i < n; i++) begin
      if (p < 256) begin
        if (p % 2 == 0) begin
          pend = 1'b1; msb = txb[i];
        end else begin
          if (pend && bwritable(p - 1) && !(p - 1 == 254 && {msb, txb[i]} == 16'h5400))
            exp_q.push_back({8'(p - 1), msb, txb[i]});
          pend = 1'b0;
        end
        p++;
      end
    end
  endtask

  task automatic cmp_commits(input string tag);
    int ng;
    ng = got_q.size() - got_base;
    check({tag, " commit count"}, 32'(ng), 32'(exp_q.size()));
    for (int i = 0; i < ng && i < exp_q.size(); i++)
      check({tag, " commit word"}, 32'(got_q[got_base + i]), 32'(exp_q[i]));
    got_base = got_q.size();
    exp_q.delete();
  endtask

  task automatic cmp_read(input string tag, input int p, input int n);
    for (int i = 0; i < n; i++) check(tag, 32'(rxb[i]), 32'(exp_rd(p + i)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    logic a0;
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R11 reset state
    check("R11 sda_oe after reset", 32'(sda_oe), 32'd0);
    check("R11 pointer after reset", 32'(rd_addr), 32'd0);

    // R1 foreign address
    bus_start(); send_byte(8'h6E, a0); send_byte(8'h0C, ackv[1]); bus_stop();
    check("R1 foreign address not acked", 32'(a0), 32'd0);
    cmp_commits("R1 foreign address");

    // R1 R2 R3 plain word write
    txb[0] = 8'hAB; txb[1] = 8'hCD;
    wr_txn(8'h0C, 2, 0);
    check("R1 own address acked", 32'(ackv[0]), 32'd1);
    check("R2 pointer byte acked", 32'(ackv[1]), 32'd1);
    model_write(8'h0C, 2); cmp_commits("R3 word order");

    // R4 two words in one frame
    txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33; txb[3] = 8'h44;
    wr_txn(8'h10, 4, 0);
    model_write(8'h10, 4); cmp_commits("R4 auto increment");

    // R6 read-only pair and out of map
    txb[0] = 8'h99; txb[1] = 8'h88;
    wr_txn(8'h04, 2, 0);
    check("R6 read-only byte still acked", 32'(ackv[3]), 32'd1);
    cmp_commits("R6 read-only pair");
    wr_txn(8'h50, 2, 0);
    cmp_commits("R6 beyond map");

    // R5 partial writes
    wr_txn(8'h20, 1, 0);
    cmp_commits("R5 lone even byte");
    wr_txn(8'h21, 2, 0);
    cmp_commits("R5 odd start");
    wr_txn(8'h20, 1, 5);
    cmp_commits("R5 cut mid byte");

    // R10 repeated START drops the held byte
    bus_start(); send_byte(8'h6C, a0); send_byte(8'h20, a0); send_byte(8'h77, a0);
    bus_start(); send_byte(8'h6C, a0); send_byte(8'h21, a0); send_byte(8'h66, a0);
    bus_stop();
    cmp_commits("R10 restart drops pending");

    // R8 R3 R4 read with repeated START
    rd_txn(8'h06, 3, 1'b1);
    check("R8 read address acked", 32'(ackv[2]), 32'd1);
    cmp_read("R8 read bytes", 8'h06, 3);

    // R7 read past the end
    rd_txn(8'hFE, 4, 1'b1);
    cmp_read("R7 past end reads FF", 8'hFE, 4);

    // R9 reset command
    txb[0] = 8'h54; txb[1] = 8'h00;
    wr_txn(8'h30, 0, 0);
    wr_txn(8'hFE, 2, 0);
    check("R9 upper command byte acked", 32'(ackv[2]), 32'd1);
    check("R9 final byte not acked", 32'(ackv[3]), 32'd0);
    check("R9 soft reset pulse", 32'(soft_cnt), 32'd1);
    check("R9 pointer cleared", 32'(rd_addr), 32'd0);
    cmp_commits("R9 no commit");
    rd_txn(8'h00, 1, 1'b0);
    cmp_read("R9 read from cleared pointer", 0, 1);

    // R9 other value commits
    txb[0] = 8'h12; txb[1] = 8'h34;
    wr_txn(8'hFE, 2, 0);
    model_write(8'hFE, 2); cmp_commits("R9 other command value");
    check("R9 no extra reset", 32'(soft_cnt), 32'd1);

    // random frames
    for (int t = 0; t < 40; t++) begin
      int p;
      int n;
      int cut;
      int rp;
      int rn;
      p = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 79) : $urandom_range(0, 255);
      n = $urandom_range(0, 6);
      cut = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        b = 8'($urandom);
        if (b == 8'h54) b = 8'h55;
        txb[i] = b;
      end
      wr_txn(8'(p), n, cut);
      for (int i = 0; i < n + 2; i++) check("R6 random byte acked", 32'(ackv[i]), 32'd1);
      model_write(p, n); cmp_commits("R5 random write");
      rp = ($urandom_range(0, 2) == 0) ? $urandom_range(250, 255) : $urandom_range(0, 255);
      rn = $urandom_range(1, 4);
      rd_txn(8'(rp), rn, 1'b1);
      cmp_read("R7 random read", rp, rn);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule